// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point numbers held in a sign / biased-exponent / fraction word. The exponent field width `EW` and the fraction width `MW` are separate parameters. Setting `EW=8, MW=23` gives a 32-bit single-precision style unit, and `EW=11, MW=52` gives a 64-bit one. Each operand pair comes with a valid strobe and an add/subtract select. Three clock edges later the result appears, together with a valid strobe and three status flags.

The work is split into three registered stages. The first stage orders the operands by magnitude and forms the exponent gap. The second shifts the smaller significand right by that gap and adds or subtracts the two significands. The third renormalizes the sum, corrects the exponent and raises the flags. There is no rounding: bits shifted out are dropped. Operands with a zero exponent field count as zero.

Top module: `fpadd_top`

## Requirements
- R1: `out_valid` is high exactly three rising clock edges after `in_valid` was sampled high, and it is low while `rst_n` is low and after reset until then.
- R2: A word is {sign in the MSB, EW-bit biased exponent with bias 2^(EW-1)-1, MW-bit fraction with an implied leading one}. Any operand whose exponent field is zero is treated as zero, whatever its fraction bits are.
- R3: When the normalized exponent reaches 2^EW-1 or more, the result is {sign, exponent all ones, fraction zero} and `out_ovf` is 1.
- R4: When the normalized exponent is 0 or below, the result is all zeros, `out_uf` is 1 and `out_zero` is 1.
- R5: `out_zero` is 1 exactly when the result's exponent and fraction are both zero. An exact cancellation gives +0 (all-zero word).
- R6: With `in_sub` = 1 the sign of operand B is inverted before the operation. Subtraction takes place when the two resulting signs differ.
- R7: The result sign is the sign of the larger-magnitude operand. Swapping A and B in an addition gives the same result.
- R8: When the exponent gap is MW+2 or more, the smaller operand contributes nothing and the result equals the larger operand.
- R9: A carry out of the significand sum shifts the significand right by one and raises the exponent by one.
- R10: After a cancellation, the significand is shifted left by its leading-zero count and that count is subtracted from the exponent.
- R11: Bits shifted out during alignment or carry normalization are discarded (truncation, no rounding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid |
| in_a | input | 1+EW+MW | Operand A |
| in_b | input | 1+EW+MW | Operand B |
| in_sub | input | 1 | 1 = A minus B, 0 = A plus B |
| out_valid | output | 1 | Result is valid |
| out_res | output | 1+EW+MW | Result word |
| out_zero | output | 1 | Result is zero |
| out_ovf | output | 1 | Exponent overflowed; result is infinity |
| out_uf | output | 1 | Exponent underflowed; result flushed to zero |

## Verification
The checker assumes that `in_valid` is a clean 0/1 level that is held low during reset. It checks the flags and the result word only in cycles where `out_valid` is high. The bench drives every operand on a falling edge, and it lowers `in_valid` between isolated transactions. Flags are therefore never judged on stale pipeline contents. The vectors use normal operands and exact zeros. The only subnormal-pattern input is the one that tests R2's flush, so every expected value follows directly from the truncating rules above.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
   typedef enum logic {
      FP_OP_ADD = 1'b0,
      FP_OP_SUB = 1'b1
   } fp_op_e;

   function automatic int max_int(input int x, input int y);
      return (x > y) ? x : y;
   endfunction
endpackage

// File: rtl/fpadd_order.sv
module fpadd_order
   import fpadd_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [EW+MW:0]      in_a,
   input  logic [EW+MW:0]      in_b,
   input  logic                in_sub,
   output logic                s1_valid,
   output logic [EW-1:0]       s1_exp,
   output logic [MW:0]         s1_big_sig,
   output logic [MW:0]         s1_small_sig,
   output logic [EW-1:0]       s1_diff,
   output logic                s1_sign,
   output fp_op_e              s1_op
);
   localparam int W = 1 + EW + MW;

   logic [EW-1:0]  a_exp, b_exp, big_exp, small_exp;
   logic           a_zero, b_zero, b_sgn, a_big;
   logic [W-2:0]   a_mag, b_mag;
   logic [MW:0]    a_sig, b_sig;

   always_comb begin
      a_exp  = in_a[MW +: EW];
      b_exp  = in_b[MW +: EW];
      a_zero = (a_exp == '0);
      b_zero = (b_exp == '0);
      a_mag  = a_zero ? '0 : in_a[W-2:0];
      b_mag  = b_zero ? '0 : in_b[W-2:0];
      a_sig  = a_zero ? '0 : {1'b1, in_a[MW-1:0]};
      b_sig  = b_zero ? '0 : {1'b1, in_b[MW-1:0]};
      b_sgn  = in_b[W-1] ^ in_sub;
      a_big  = (a_mag >= b_mag);
      big_exp   = a_big ? (a_zero ? '0 : a_exp) : (b_zero ? '0 : b_exp);
      small_exp = a_big ? (b_zero ? '0 : b_exp) : (a_zero ? '0 : a_exp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid     <= 1'b0;
         s1_exp       <= '0;
         s1_big_sig   <= '0;
         s1_small_sig <= '0;
         s1_diff      <= '0;
         s1_sign      <= 1'b0;
         s1_op        <= FP_OP_ADD;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_exp       <= big_exp;
            s1_big_sig   <= a_big ? a_sig : b_sig;
            s1_small_sig <= a_big ? b_sig : a_sig;
            s1_diff      <= big_exp - small_exp;
            s1_sign      <= a_big ? in_a[W-1] : b_sgn;
            s1_op        <= (in_a[W-1] != b_sgn) ? FP_OP_SUB : FP_OP_ADD;
         end
      end
   end
endmodule

// File: rtl/fpadd_align_add.sv
module fpadd_align_add
   import fpadd_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s1_valid,
   input  logic [EW-1:0]       s1_exp,
   input  logic [MW:0]         s1_big_sig,
   input  logic [MW:0]         s1_small_sig,
   input  logic [EW-1:0]       s1_diff,
   input  logic                s1_sign,
   input  fp_op_e              s1_op,
   output logic                s2_valid,
   output logic [EW-1:0]       s2_exp,
   output logic [MW+1:0]      s2_sum,
   output logic                s2_sign
);
   localparam int SIGW = MW + 1;
   localparam int SUMW = MW + 2;
   localparam int SHW  = $clog2(SUMW);
   localparam int DW   = max_int(EW, SHW) + 1;

   logic [DW-1:0]   diff_x;
   logic            far;
   logic [SIGW-1:0] stg [SHW+1];
   logic [SIGW-1:0] aligned;
   logic [SUMW-1:0] sum;

   assign diff_x = DW'(s1_diff);
   assign far    = (diff_x >= DW'(SUMW));
   assign stg[0] = s1_small_sig;

   for (genvar s = 0; s < SHW; s++) begin : g_shift
      assign stg[s+1] = diff_x[s] ? (stg[s] >> (1 << s)) : stg[s];
   end

   assign aligned = far ? '0 : stg[SHW];

   always_comb begin
      if (s1_op == FP_OP_SUB)
         sum = {1'b0, s1_big_sig} - {1'b0, aligned};
      else
         sum = {1'b0, s1_big_sig} + {1'b0, aligned};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_exp   <= '0;
         s2_sum   <= '0;
         s2_sign  <= 1'b0;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) begin
            s2_exp  <= s1_exp;
            s2_sum  <= sum;
            s2_sign <= s1_sign;
         end
      end
   end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
   import fpadd_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s2_valid,
   input  logic [EW-1:0]       s2_exp,
   input  logic [MW+1:0]      s2_sum,
   input  logic                s2_sign,
   output logic                out_valid,
   output logic [EW+MW:0]      out_res,
   output logic                out_zero,
   output logic                out_ovf,
   output logic                out_uf
);
   localparam int SIGW    = MW + 1;
   localparam int LZW     = $clog2(SIGW + 1);
   localparam int XW      = max_int(EW, LZW) + 2;
   localparam int EXP_MAX = (1 << EW) - 1;

   logic [LZW-1:0]        lzc;
   logic                  carry, sum_zero, ovf, uf;
   logic [MW-1:0]         man;
   logic signed [XW-1:0]  e_base, e_lz, e_n;
   logic [EW+MW:0]        res;

   always_comb begin
      lzc = LZW'(SIGW);
      for (int i = 0; i < SIGW; i++)
         if (s2_sum[i]) lzc = LZW'(SIGW - 1 - i);
   end

   always_comb begin
      carry    = s2_sum[MW+1];
      sum_zero = (s2_sum == '0);
      e_base   = $signed(XW'(s2_exp));
      e_lz     = $signed(XW'(lzc));
      if (carry) begin
         man = s2_sum[MW:1];
         e_n = e_base + XW'(1);
      end else begin
         man = MW'(s2_sum[SIGW-1:0] << lzc);
         e_n = e_base - e_lz;
      end
      ovf = !sum_zero && (e_n >= $signed(XW'(EXP_MAX)));
      uf  = !sum_zero && (e_n <= $signed(XW'(0)));
      if (sum_zero || uf)
         res = '0;
      else if (ovf)
         res = {s2_sign, {EW{1'b1}}, {MW{1'b0}}};
      else
         res = {s2_sign, e_n[EW-1:0], man};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
         out_zero  <= 1'b0;
         out_ovf   <= 1'b0;
         out_uf    <= 1'b0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) begin
            out_res  <= res;
            out_zero <= sum_zero || uf;
            out_ovf  <= ovf;
            out_uf   <= uf;
         end
      end
   end
endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
   import fpadd_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [EW+MW:0]   in_a,
   input  logic [EW+MW:0]   in_b,
   input  logic             in_sub,
   output logic             out_valid,
   output logic [EW+MW:0]   out_res,
   output logic             out_zero,
   output logic             out_ovf,
   output logic             out_uf
);
   if (EW < 2) begin : g_bad_ew
      $error("fpadd_top: EW must be at least 2");
   end
   if (MW < 1) begin : g_bad_mw
      $error("fpadd_top: MW must be at least 1");
   end

   logic             s1_valid, s1_sign;
   logic [EW-1:0]    s1_exp, s1_diff;
   logic [MW:0]      s1_big_sig, s1_small_sig;
   fp_op_e           s1_op;
   logic             s2_valid, s2_sign;
   logic [EW-1:0]    s2_exp;
   logic [MW+1:0]    s2_sum;

   fpadd_order #(.EW(EW), .MW(MW)) u_order (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
      .s1_valid(s1_valid), .s1_exp(s1_exp), .s1_big_sig(s1_big_sig),
      .s1_small_sig(s1_small_sig), .s1_diff(s1_diff),
      .s1_sign(s1_sign), .s1_op(s1_op)
   );

   fpadd_align_add #(.EW(EW), .MW(MW)) u_align (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_exp(s1_exp),
      .s1_big_sig(s1_big_sig), .s1_small_sig(s1_small_sig),
      .s1_diff(s1_diff), .s1_sign(s1_sign), .s1_op(s1_op),
      .s2_valid(s2_valid), .s2_exp(s2_exp), .s2_sum(s2_sum),
      .s2_sign(s2_sign)
   );

   fpadd_norm #(.EW(EW), .MW(MW)) u_norm (
      .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_exp(s2_exp),
      .s2_sum(s2_sum), .s2_sign(s2_sign),
      .out_valid(out_valid), .out_res(out_res), .out_zero(out_zero),
      .out_ovf(out_ovf), .out_uf(out_uf)
   );
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             out_valid,
   input  logic [EW+MW:0]   out_res,
   input  logic             out_zero,
   input  logic             out_ovf,
   input  logic             out_uf
);
   logic [2:0] vpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[1:0], in_valid};
   end

   // R1: valid emerges three edges after it enters
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vpipe[2]);

   // R3: overflow saturates to infinity
   a_r3_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ovf) |->
         (out_res[MW +: EW] == {EW{1'b1}}) && (out_res[MW-1:0] == '0));

   // R4: underflow flushes the word to zero
   a_r4_uf_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_uf) |-> (out_zero && (out_res == '0)));

   // R5: zero flag agrees with the result word
   a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_zero == (out_res[EW+MW-1:0] == '0)));

   // R3 and R4 cannot both hold
   a_r3_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_ovf && out_uf));
endmodule

bind fpadd_top fpadd_chk #(.EW(EW), .MW(MW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .out_res(out_res), .out_zero(out_zero), .out_ovf(out_ovf), .out_uf(out_uf)
);

// File: tb/fpadd_top_tb_top.sv
module fpadd_top_tb_top;
   localparam int N = 15;

   localparam logic [31:0] VA [N] = '{
      32'h3F800000, 32'h40000000, 32'h3F800000, 32'h3FC00000, 32'h3F800000,
      32'h3F800000, 32'h00000000, 32'h7F000000, 32'h00C00000, 32'h40400000,
      32'h3F800000, 32'hC0400000, 32'h3F800000, 32'h3F800001, 32'h00400000};
   localparam logic [31:0] VB [N] = '{
      32'h3F800000, 32'h3F800000, 32'hBF800000, 32'h3E800000, 32'h40000000,
      32'h30800000, 32'h40400000, 32'h7F000000, 32'h00800000, 32'h3F800000,
      32'h3F7FFFFF, 32'h3F800000, 32'h40400000, 32'h3F800000, 32'h3F800000};
   localparam logic VS [N] = '{
      1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
      1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam logic [31:0] VE [N] = '{
      32'h40000000, 32'h3F800000, 32'h00000000, 32'h3FE00000, 32'hBF800000,
      32'h3F800000, 32'h40400000, 32'h7F800000, 32'h00000000, 32'h40800000,
      32'h34000000, 32'hC0000000, 32'h40800000, 32'h40000000, 32'h3F800000};
   // flags {zero, ovf, uf}
   localparam logic [2:0] VF [N] = '{
      3'b000, 3'b000, 3'b100, 3'b000, 3'b000, 3'b000, 3'b000, 3'b010,
      3'b101, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000};
   localparam string VR [N] = '{
      "R9", "R6", "R5", "R2", "R6/R7", "R8", "R2", "R3", "R4", "R9",
      "R10/R11", "R7", "R7", "R11", "R2"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        in_sub = 1'b0;
   logic        out_valid, out_zero, out_ovf, out_uf;
   logic [31:0] out_res;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   fpadd_top #(.EW(8), .MW(23)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
      .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
      .out_res(out_res), .out_zero(out_zero), .out_ovf(out_ovf),
      .out_uf(out_uf)
   );

   task automatic check_out(input string req, input logic [31:0] exp_res,
                            input logic [2:0] exp_flg);
      checks++;
      if (!out_valid || out_res !== exp_res ||
          {out_zero, out_ovf, out_uf} !== exp_flg) begin
         errors++;
         $display("FAIL %s: valid=%b res=%h flags=%b expected valid=1 res=%h flags=%b",
                  req, out_valid, out_res, {out_zero, out_ovf, out_uf},
                  exp_res, exp_flg);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp_v);
      end
   endtask

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic s);
      in_a = a; in_b = b; in_sub = s; in_valid = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_bit("R1 reset valid", out_valid, 1'b0);
      check_bit("R1 reset zero", out_zero, 1'b0);
      check_bit("R1 reset res", out_res == 32'h0, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: one isolated transaction per vector
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         drive(VA[i], VB[i], VS[i]);
         @(negedge clk);
         in_valid = 1'b0;
         check_bit({VR[i], " R1 not early"}, out_valid, 1'b0);
         @(negedge clk);
         @(negedge clk);
         check_out(VR[i], VE[i], VF[i]);
      end

      // R7: A+B equals B+A under swap (3+1 vs 1+3)
      // R1: back-to-back stream, one result per cycle
      @(negedge clk);
      drive(32'h40400000, 32'h3F800000, 1'b0);
      @(negedge clk);
      drive(32'h3F800000, 32'h40400000, 1'b0);
      @(negedge clk);
      drive(32'h7F000000, 32'h7F000000, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check_out("R1 stream0", 32'h40800000, 3'b000);
      @(negedge clk);
      check_out("R7 stream1 swapped", 32'h40800000, 3'b000);
      @(negedge clk);
      check_out("R3 stream2", 32'h7F800000, 3'b010);
      @(negedge clk);
      check_bit("R1 bubble", out_valid, 1'b0);

      // R1: reset in mid-flight clears the valid pipeline
      drive(32'h3F800000, 32'h3F800000, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check_bit("R1 flushed by reset", out_valid, 1'b0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule